// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block produces the time-of-day tick interrupt for a small 8-bit processor system. A divider counts system clocks and marks the end of every period. At each such mark the block bumps an 8-bit tick counter and lowers an active-low interrupt request line, `irq_n`.

The request can behave in one of two ways, chosen by the `sticky_mode` input.

- **Pulse mode.** The line is held low for a fixed number of clocks. That width is sized so that a CPU is sure to see it: the CPU samples its interrupt input only when an instruction finishes, and an instruction can last up to 23 T-cycles.
- **Sticky mode.** The line stays low until software reads the tick counter. A tick that arrives while a request is still unserviced is recorded as an overrun.

Software reads the block through a one-bit-addressed read port. The data is combinational from the address. Side effects of a read take place at the clock edge on which `rd_en` is high.

Top module: `tick_irq_gen`

## Requirements
- R1: The divider runs from 0 to PERIOD-1 and then restarts, so the block produces one tick every PERIOD clocks. The first tick takes effect on the PERIOD-th clock edge after reset is released. The defaults are PERIOD = 1,000,000 and PULSE_W = 255.
- R2: In pulse mode (`sticky_mode` = 0), `irq_n` goes low on the same edge at which a tick takes effect.
- R3: In pulse mode, `irq_n` stays low for exactly PULSE_W clocks and then returns high until the next tick.
- R4: PERIOD must be greater than PULSE_W. A new tick must never arrive while a pulse is still running; an assertion flags this.
- R5: In sticky mode (`sticky_mode` = 1), a tick sets a pending request and drives `irq_n` low. The request holds until a read of address 0. A read of address 1 leaves it set.
- R6: A read of address 0 returns the 8-bit tick counter. The counter rises by one on every tick and wraps from 255 to 0. In pulse mode, reading it has no effect on `irq_n`.
- R7: A read of address 1 returns the status byte. Bit 7 is the overrun flag, bit 0 is the pending request, and bits 6:1 read as zero. A tick that arrives while a request is pending sets the overrun flag. A read of address 1 clears it.
- R8: If a read of address 0 and a tick fall on the same edge, the request stays pending and no overrun is recorded.
- R9: A synchronous reset (`rst` high at a clock edge) does the following:
  - clears the divider, the tick counter and the status;
  - drives `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sticky_mode | input | 1 | 0 selects the timed pulse, 1 selects the request that is held until read |
| rd_en | input | 1 | Read strobe; the read's side effects happen at this clock edge |
| rd_addr | input | 1 | 0 selects the tick counter, 1 selects the status byte |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A tick takes effect on the PERIOD-th edge after the divider restarts. The counter, `irq_n` and status bit 0 all change on that same edge, and in pulse mode `irq_n` rises again PULSE_W edges later. A read's side effects appear one edge after the strobe, while the data it returns is the value from before that edge. The bench counts edges since reset, drives inputs just after the falling edge, and samples one nanosecond later. Each expected value is therefore compared on the edge count at which the requirement places it, and the wrap and read/tick collision cases are placed on exact edge counts.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic {
    SEL_COUNT  = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  // status byte: overrun at the top, pending at the bottom
  function automatic logic [REG_W-1:0] pack_status(input logic ovr, input logic pend);
    pack_status = {ovr, {(REG_W-2){1'b0}}, pend};
  endfunction

  function automatic logic [REG_W-1:0] count_next(input logic [REG_W-1:0] cur);
    count_next = cur + {{(REG_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/period_divider.sv
module period_divider #(
  parameter int PERIOD = 1000000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: ticks are separated by a full period, never adjacent
  a_r1_no_adjacent_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int WIDTH = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int LW = $clog2(WIDTH + 1);
  localparam logic [LW-1:0] LOAD = LW'(WIDTH);

  logic [LW-1:0] left;

  assign active = (left != '0);

  always_ff @(posedge clk) begin
    if (rst)         left <= '0;
    else if (start)  left <= LOAD;
    else if (active) left <= left - 1'b1;
  end

  // R4: the period must outlast the pulse, so a start never finds it running
  a_r4_period_exceeds_width: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
  // R3: a start always opens a pulse
  a_r3_start_opens_pulse: assert property (@(posedge clk) disable iff (rst)
    start |=> active);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic set,
  input  logic clr_pend,
  input  logic clr_ovr,
  output logic pending,
  output logic overrun
);
  logic set_eff;
  logic lost;

  assign set_eff = enable & set;
  assign lost    = set_eff & pending & ~clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (set_eff)       pending <= 1'b1;
      else if (clr_pend) pending <= 1'b0;
      if (lost)          overrun <= 1'b1;
      else if (clr_ovr)  overrun <= 1'b0;
    end
  end

  // R5: a pending request survives until the counter read
  a_r5_hold_until_read: assert property (@(posedge clk) disable iff (rst)
    (pending && !clr_pend) |=> pending);
  // R7: overrun only appears when a request was already pending
  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(pending));
  // R8: a read colliding with a tick records no overrun
  a_r8_collision_clean: assert property (@(posedge clk) disable iff (rst)
    (set_eff && clr_pend && !overrun) |=> !overrun);
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen #(
  parameter int PERIOD  = 1000000,
  parameter int PULSE_W = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sticky_mode,
  input  logic       rd_en,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  import tick_irq_pkg::*;

  logic             tick;
  logic             pulse_active;
  logic             pending;
  logic             overrun;
  logic             rd_count;
  logic             rd_status;
  logic [REG_W-1:0] tick_count;

  assign rd_count  = rd_en && (rd_addr == SEL_COUNT);
  assign rd_status = rd_en && (rd_addr == SEL_STATUS);

  period_divider #(.PERIOD(PERIOD)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  pulse_stretch #(.WIDTH(PULSE_W)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .start  (tick),
    .active (pulse_active)
  );

  sticky_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .enable   (sticky_mode),
    .set      (tick),
    .clr_pend (rd_count),
    .clr_ovr  (rd_status),
    .pending  (pending),
    .overrun  (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst)       tick_count <= '0;
    else if (tick) tick_count <= count_next(tick_count);
  end

  assign rd_data = (rd_addr == SEL_STATUS) ? pack_status(overrun, pending) : tick_count;
  assign irq_n   = sticky_mode ? ~pending : ~pulse_active;

  // R6: every tick advances the counter by one, modulo 256
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> tick_count == REG_W'($past(tick_count) + 1));
  // R2: the request line only falls as a result of a tick
  a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(tick));
  // R9: reset leaves the line released
  a_r9_reset_released: assert property (@(posedge clk)
    $past(rst) |-> irq_n);
endmodule

// File: tb/test_tick_irq_gen.sv
module test_tick_irq_gen;
  localparam int P = 20;
  localparam int W = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sticky_mode = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_irq_gen #(.PERIOD(P), .PULSE_W(W)) i_tick_irq_gen (
    .clk(clk), .rst(rst), .sticky_mode(sticky_mode), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  // pulse-mode vectors: edge count since reset, expected irq_n, expected count
  localparam int NV = 8;
  localparam int VK[NV]   = '{19, 20, 24, 25, 39, 40, 44, 45};
  localparam int VIRQ[NV] = '{1, 0, 0, 1, 1, 0, 0, 1};
  localparam int VCNT[NV] = '{0, 1, 1, 1, 1, 2, 2, 2};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, k);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic goto(input int target);
    while (k < target) step();
  endtask

  task automatic peek(input logic a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic do_read(input logic a, output int v);
    rd_addr = a;
    rd_en = 1'b1;
    #1;
    v = int'(rd_data);
    step();
    rd_en = 1'b0;
  endtask

  task automatic apply_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1;
    sticky_mode = mode;
    step();
    step();
    rst = 1'b0;
    k = 0;
  endtask

  initial begin
    int v;
    apply_reset(1'b0);
    #1;
    check("R9 irq_n after reset", int'(irq_n), 1);
    peek(1'b0, v); check("R9 count after reset", v, 0);
    peek(1'b1, v); check("R9 status after reset", v, 0);
    rd_addr = 1'b0;

    // table walk, pulse mode (R1 R2 R3 R6)
    for (int i = 0; i < NV; i++) begin
      goto(VK[i]);
      #1;
      check("R2/R3 pulse irq_n", int'(irq_n), VIRQ[i]);
      peek(1'b0, v);
      check("R1/R6 tick count", v, VCNT[i]);
    end

    // R6: counter read in pulse mode leaves the pulse alone
    goto(60);
    do_read(1'b0, v);
    check("R6 count read in pulse mode", v, 3);
    #1;
    check("R6 irq_n unaffected by read", int'(irq_n), 0);
    peek(1'b1, v); check("R7 status idle in pulse mode", v, 0);

    // R6: wrap
    goto(255 * P);
    peek(1'b0, v); check("R6 count at 255", v, 255);
    goto(256 * P);
    peek(1'b0, v); check("R6 count wraps to 0", v, 0);
    #1;
    check("R2 irq_n low on wrapping tick", int'(irq_n), 0);

    // R9 mid-run reset, switching to sticky mode
    step();
    apply_reset(1'b1);
    #1;
    check("R9 irq_n after mid-run reset", int'(irq_n), 1);
    peek(1'b0, v); check("R9 count after mid-run reset", v, 0);

    // R5 sticky hold
    goto(20);
    #1; check("R5 sticky irq_n low", int'(irq_n), 0);
    peek(1'b1, v); check("R7 status pending", v, 8'h01);
    goto(25);
    #1; check("R5 sticky holds past width", int'(irq_n), 0);
    do_read(1'b0, v);
    check("R6 count read sticky", v, 1);
    #1; check("R5 read releases irq_n", int'(irq_n), 1);
    peek(1'b1, v); check("R7 status cleared", v, 0);

    // R7 overrun
    goto(40);
    #1; check("R5 second tick irq_n low", int'(irq_n), 0);
    goto(60);
    peek(1'b1, v); check("R7 overrun set", v, 8'h81);
    do_read(1'b1, v);
    check("R7 status read value", v, 8'h81);
    peek(1'b1, v); check("R7 overrun cleared, pending kept", v, 8'h01);
    #1; check("R5 status read keeps irq_n low", int'(irq_n), 0);
    do_read(1'b0, v);
    check("R6 count before clear", v, 3);
    #1; check("R5 irq_n released", int'(irq_n), 1);
    peek(1'b1, v); check("R7 status empty", v, 0);

    // R8 read colliding with a tick
    goto(99);
    do_read(1'b0, v);
    check("R8 count read at collision", v, 4);
    #1; check("R8 request kept", int'(irq_n), 0);
    peek(1'b1, v); check("R8 no overrun", v, 8'h01);
    peek(1'b0, v); check("R8 count advanced", v, 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule